// File: doc/BRIEF.md
# Recursive-Form PID Control Datapath

This block turns a stream of signed fixed-point error samples into a stream of control values. It uses the recursive (velocity) form of a discrete PID law. Each new control value is a weighted sum of five terms: the current error, the two errors before it, and the two most recent control values. The five weights come from an external tuning engine. They are loaded as a set with a single strobe. Turning proportional, integral and derivative gains into these five weights is done outside the block.

The arithmetic is split into five register stages so the multipliers do not limit the clock rate. The two feedback terms must always be current, so only one sample is in flight at a time. The input side stays not-ready until the previous result has left the pipeline and has been taken by the consumer. Both stream sides use valid/ready. An input is taken on a cycle where `in_valid` and `in_ready` are both high. An output stays on the port, unchanged, until `out_ready` is high while `out_valid` is high. While an output is held back, no new sample is accepted.

Top module: `pid_recur_core`

## Requirements
- R1: With history h = (e0, e1, e2, u1, u2) and weights k0..k4 in Q(FRAC) format, the output is the saturated value of floor((k0*e0 + k1*e1 + k2*e2 + k3*u1 + k4*u2 + 2^(FRAC-1)) / 2^FRAC). All products and sums keep full precision, and the result is rounded half-up.
- R2: A result above 2^(DW-1)-1 is clamped to 2^(DW-1)-1. A result below -2^(DW-1) is clamped to -2^(DW-1).
- R3: An accepted sample produces `out_valid` exactly five rising edges after it is accepted, counting the accepting edge.
- R4: Each accepted sample becomes e0. The previous e0 moves to e1, and the previous e1 moves to e2.
- R5: When a result leaves the pipeline, that same saturated value becomes u1, and the previous u1 moves to u2.
- R6: `in_ready` is low while a sample is in flight and while an output waits for `out_ready`. A sample offered in that time is ignored and produces no output.
- R7: While `out_valid` is high and `out_ready` is low, `out_u` and `out_valid` hold steady.
- R8: Synchronous `rst` clears the weights, all history, the pipeline and `out_u` to zero and drops `out_valid`.
- R9: `coef_load` captures all five weights. In the same cycle it clears the history, discards any sample in flight and any pending output, and holds `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_load | input | 1 | Capture the five weights and clear the history |
| k_e0 | input | CW | Weight of e(n), signed Q(FRAC) |
| k_e1 | input | CW | Weight of e(n-1) |
| k_e2 | input | CW | Weight of e(n-2) |
| k_u1 | input | CW | Weight of u(n-1) |
| k_u2 | input | CW | Weight of u(n-2) |
| in_valid | input | 1 | Error sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_err | input | DW | Signed error sample |
| out_valid | output | 1 | Control value valid |
| out_ready | input | 1 | Consumer takes the control value |
| out_u | output | DW | Signed control value |

## Verification
The bench drives errors whose unrounded results fall just below and just above a half LSB. A design that truncates, or rounds half away from zero, returns an output one LSB off. It pushes both feedback weights and large errors past full scale. A design that wraps instead of clamping flips sign, and one that feeds back the unsaturated value drifts away from the model on the following samples. It offers samples while the block is busy or held back. A design that accepts them emits extra outputs or shifts the error history early. It also reloads the weights with a sample in flight. A design that keeps stale history or lets the old result out then fails the next comparison.

// File: rtl/pid_pkg.sv
package pid_pkg;
  // Tap order shared by the history file and the multiplier bank.
  localparam int unsigned NTAP = 5;
  localparam int unsigned T_E0 = 0;
  localparam int unsigned T_E1 = 1;
  localparam int unsigned T_E2 = 2;
  localparam int unsigned T_U1 = 3;
  localparam int unsigned T_U2 = 4;
  localparam int unsigned MAC_STAGES = 3;
endpackage

// File: rtl/pid_hist.sv
module pid_hist
  import pid_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     shift_e,
  input  logic [DW-1:0]            e_new,
  input  logic                     shift_u,
  input  logic [DW-1:0]            u_new,
  output logic [NTAP-1:0][DW-1:0]  taps
);
  logic [NTAP-1:0][DW-1:0] h;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      h <= '0;
    end else begin
      if (shift_e) begin
        h[T_E0] <= e_new;
        h[T_E1] <= h[T_E0];
        h[T_E2] <= h[T_E1];
      end
      if (shift_u) begin
        h[T_U1] <= u_new;
        h[T_U2] <= h[T_U1];
      end
    end
  end

  assign taps = h;

  // R4: error history moves one place per accepted sample
  p_err_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (shift_e && !clr) |=> (taps[T_E1] == $past(taps[T_E0]) && taps[T_E0] == $past(e_new)));
  // R9: a reload leaves every history entry at zero
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (taps == '0));
endmodule

// File: rtl/pid_mac.sv
module pid_mac
  import pid_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 18,
  parameter int unsigned FRAC = 12,
  parameter int unsigned SW   = DW + CW + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     in_v,
  input  logic [NTAP-1:0][DW-1:0]  taps,
  input  logic [NTAP-1:0][CW-1:0]  coefs,
  output logic signed [SW-1:0]     sum,
  output logic [MAC_STAGES-1:0]    stv
);
  localparam int unsigned PW = DW + CW;
  localparam logic signed [SW-1:0] RND =
    {{(SW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [PW-1:0] prod [NTAP];
  logic signed [SW-1:0] s01, s23, s4;
  logic v2, v3, v4;

  // stage 2: one multiplier per tap
  for (genvar i = 0; i < NTAP; i++) begin : g_mul
    always_ff @(posedge clk) begin
      if (rst) prod[i] <= '0;
      else if (in_v) prod[i] <= PW'($signed(taps[i])) * PW'($signed(coefs[i]));
    end
  end

  // stage 3 and stage 4: adder tree with rounding offset
  always_ff @(posedge clk) begin
    if (rst) begin
      s01 <= '0; s23 <= '0; s4 <= '0; sum <= '0;
    end else begin
      if (v2) begin
        s01 <= SW'(prod[T_E0]) + SW'(prod[T_E1]);
        s23 <= SW'(prod[T_E2]) + SW'(prod[T_U1]);
        s4  <= SW'(prod[T_U2]);
      end
      if (v3) sum <= s01 + s23 + s4 + RND;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
    end else begin
      v2 <= in_v; v3 <= v2; v4 <= v3;
    end
  end

  assign stv = {v4, v3, v2};

  // R3: each stage hands on to the next in one cycle
  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    ((in_v || v2 || v3) && !flush) |=> (v2 || v3 || v4));
endmodule

// File: rtl/pid_sat.sv
module pid_sat #(
  parameter int unsigned DW   = 16,
  parameter int unsigned FRAC = 12,
  parameter int unsigned SW   = 37
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 in_v,
  input  logic signed [SW-1:0] sum,
  input  logic                 out_ready,
  output logic signed [DW-1:0] u_sat,
  output logic signed [DW-1:0] out_u,
  output logic                 out_valid
);
  localparam logic signed [SW-1:0] UMAX = SW'({1'b0, {(DW-1){1'b1}}});
  localparam logic signed [SW-1:0] UMIN = ~UMAX;

  logic signed [SW-1:0] q;

  always_comb begin
    q = sum >>> FRAC;
    if (q > UMAX)      u_sat = UMAX[DW-1:0];
    else if (q < UMIN) u_sat = UMIN[DW-1:0];
    else               u_sat = q[DW-1:0];
  end

  // stage 5: output register, held under back-pressure
  always_ff @(posedge clk) begin
    if (rst) begin
      out_u     <= '0;
      out_valid <= 1'b0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (in_v) begin
      out_u     <= u_sat;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5: the value presented is the clamped sum of the previous cycle
  p_result_r5: assert property (@(posedge clk) disable iff (rst)
    (in_v && !flush) |=> (out_valid && out_u == $past(u_sat)));
  // R7: a held output does not change
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush && !in_v) |=> (out_valid && $stable(out_u)));
endmodule

// File: rtl/pid_recur_core.sv
module pid_recur_core
  import pid_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 18,
  parameter int unsigned FRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 coef_load,
  input  logic signed [CW-1:0] k_e0,
  input  logic signed [CW-1:0] k_e1,
  input  logic signed [CW-1:0] k_e2,
  input  logic signed [CW-1:0] k_u1,
  input  logic signed [CW-1:0] k_u2,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_err,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_u
);
  localparam int unsigned SW = DW + CW + 3;

  logic [NTAP-1:0][CW-1:0] kreg;
  logic [NTAP-1:0][DW-1:0] taps;
  logic [MAC_STAGES-1:0]   stv;
  logic signed [SW-1:0]    sum;
  logic signed [DW-1:0]    u_sat;
  logic v1, accept, wb, busy;

  always_ff @(posedge clk) begin
    if (rst) kreg <= '0;
    else if (coef_load) begin
      kreg[T_E0] <= k_e0;
      kreg[T_E1] <= k_e1;
      kreg[T_E2] <= k_e2;
      kreg[T_U1] <= k_u1;
      kreg[T_U2] <= k_u2;
    end
  end

  assign busy     = v1 || (|stv);
  assign in_ready = !busy && !(out_valid && !out_ready) && !coef_load;
  assign accept   = in_valid && in_ready;
  assign wb       = stv[MAC_STAGES-1] && !coef_load;

  // stage 1: capture sample into history
  always_ff @(posedge clk) begin
    if (rst || coef_load) v1 <= 1'b0;
    else                  v1 <= accept;
  end

  pid_hist #(.DW(DW)) u_hist (
    .clk(clk), .rst(rst), .clr(coef_load),
    .shift_e(accept), .e_new(in_err),
    .shift_u(wb), .u_new(u_sat),
    .taps(taps)
  );

  pid_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .SW(SW)) u_mac (
    .clk(clk), .rst(rst), .flush(coef_load), .in_v(v1),
    .taps(taps), .coefs(kreg), .sum(sum), .stv(stv)
  );

  pid_sat #(.DW(DW), .FRAC(FRAC), .SW(SW)) u_sat_stage (
    .clk(clk), .rst(rst), .flush(coef_load), .in_v(stv[MAC_STAGES-1]),
    .sum(sum), .out_ready(out_ready), .u_sat(u_sat),
    .out_u(out_u), .out_valid(out_valid)
  );

  // R6: at most one sample anywhere in the pipeline
  p_single_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({v1, stv, out_valid && !out_ready}));
  // R6: nothing is taken while a result waits
  p_no_take_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !accept);
  // R3: last arithmetic stage reaches the port next cycle
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    wb |=> out_valid);
  // R8: reset leaves no output pending
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_u == '0));
endmodule

// File: tb/test_pid_recur_core.sv
module test_pid_recur_core;
  localparam int DW = 16, CW = 18, FRAC = 12;
  localparam int VEC_N = 12;
  localparam logic signed [DW-1:0] VEC_E [VEC_N] = '{
    16'sd1000, 16'sd2000, -16'sd500, 16'sd0, 16'sd4000, -16'sd8000,
    16'sd12000, 16'sd32767, -16'sd32768, 16'sd300, -16'sd300, 16'sd0};

  logic clk = 0, rst = 1, coef_load = 0, in_valid = 0, out_ready = 1;
  logic signed [CW-1:0] k_e0 = 0, k_e1 = 0, k_e2 = 0, k_u1 = 0, k_u2 = 0;
  logic signed [DW-1:0] in_err = 0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] out_u;

  int vectors = 0, miscompares = 0;
  longint me0, me1, me2, mu1, mu2;
  longint mk [5];

  always #10 clk = ~clk;

  pid_recur_core #(.DW(DW), .CW(CW), .FRAC(FRAC)) i_pid_recur_core (
    .clk(clk), .rst(rst), .coef_load(coef_load),
    .k_e0(k_e0), .k_e1(k_e1), .k_e2(k_e2), .k_u1(k_u1), .k_u2(k_u2),
    .in_valid(in_valid), .in_ready(in_ready), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_u(out_u));

  task automatic chk(input longint act, input longint exp, input string req);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    me0 = 0; me1 = 0; me2 = 0; mu1 = 0; mu2 = 0;
  endfunction

  function automatic longint model(input longint e);
    longint s, q, hi, lo;
    hi = (longint'(1) <<< (DW-1)) - 1;
    lo = -hi - 1;
    me2 = me1; me1 = me0; me0 = e;
    s = mk[0]*me0 + mk[1]*me1 + mk[2]*me2 + mk[3]*mu1 + mk[4]*mu2
        + (longint'(1) <<< (FRAC-1));
    q = s >>> FRAC;
    if (q > hi) q = hi;
    else if (q < lo) q = lo;
    mu2 = mu1; mu1 = q;
    return q;
  endfunction

  task automatic load(input longint a, b, c, d, e);
    @(negedge clk);
    k_e0 = CW'(a); k_e1 = CW'(b); k_e2 = CW'(c); k_u1 = CW'(d); k_u2 = CW'(e);
    coef_load = 1;
    #1 chk(longint'(in_ready), 0, "R9 ready low during reload");
    @(posedge clk);
    @(negedge clk);
    coef_load = 0;
    mk[0] = a; mk[1] = b; mk[2] = c; mk[3] = d; mk[4] = e;
    model_clear();
  endtask

  task automatic run_sample(input logic signed [DW-1:0] e, input string req);
    longint exp;
    int lat;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_err = e; exp = model(longint'(e));
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(longint'(in_ready), 0, "R6 busy after accept");
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat, 5, "R3 latency");
    chk(longint'(out_u), exp, req);
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(longint'(out_valid), 0, req);
    end
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic signed [DW-1:0] held;
    model_clear();
    for (int i = 0; i < 5; i++) mk[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(longint'(out_valid), 0, "R8 reset out_valid");
    chk(longint'(out_u), 0, "R8 reset out_u");
    rst = 0;
    @(negedge clk);
    chk(longint'(in_ready), 1, "R8 ready after reset");

    // table walk: R1 R4 R5 through feedback, R2 via large errors
    load(6144, -5120, 512, 2048, 1024);
    for (int v = 0; v < VEC_N; v++) run_sample(VEC_E[v], "R1 R4 R5 table");

    // R1 rounding at the half-LSB boundary
    load(1, 0, 0, 0, 0);
    run_sample(16'sd2048, "R1 round up at half");
    run_sample(16'sd2047, "R1 below half");
    run_sample(-16'sd2048, "R1 negative half");
    run_sample(-16'sd2049, "R1 negative beyond half");

    // R2 clamping both ways, then with feedback pushing past full scale
    load(16384, 0, 0, 0, 0);
    run_sample(16'sd10000, "R2 clamp high");
    run_sample(-16'sd10000, "R2 clamp low");
    load(4096, 0, 0, 8192, -4096);
    for (int i = 0; i < 6; i++) run_sample(16'sd20000, "R2 R5 feedback clamp");

    // R7 hold under back-pressure, R6 offered sample ignored
    load(4096, 4096, 0, 0, 0);
    out_ready = 0;
    run_sample(16'sd700, "R7 first value");
    held = out_u;
    in_valid = 1; in_err = 16'sd9999;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(longint'(out_u), longint'(held), "R7 value held");
      chk(longint'(out_valid), 1, "R7 valid held");
      chk(longint'(in_ready), 0, "R6 ready low while held");
    end
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    quiet(7, "R6 offered sample ignored");
    run_sample(16'sd100, "R4 history unaffected by ignored sample");

    // R9 reload with a sample in flight
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_err = 16'sd5000;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    load(8192, 4096, 4096, 4096, 4096);
    quiet(7, "R9 flushed sample gives no output");
    run_sample(16'sd300, "R9 history cleared after reload");

    // R8 mid-run reset clears weights and history
    run_sample(16'sd1234, "R1 before reset");
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 5; i++) mk[i] = 0;
    model_clear();
    run_sample(16'sd5000, "R8 weights cleared by reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule